// File: doc/BRIEF.md
# Receive FIFO Periodic Flush Timer

This block counts macroticks so that a receive FIFO raises its almost-full interrupt even when its fill level stays below the watermark. Without it, a few frames could sit in the FIFO for a long time. The timer restarts at every communication-cycle start and also restarts each time it expires. Each expiry raises a sticky interrupt flag, but only if the FIFO holds data and the watermark has not already been reached. Software clears that flag with a one-clock pulse.

Software programs the 14-bit period while the configuration enable is high. Two reserved values change how the timer behaves. A period of zero keeps the timer expired at all times. A period of all ones stops it from ever expiring. Any other value is a normal period, counted in macroticks.

Top module: `fifo_flush_timer`

## Requirements
- R1: `dur_in` is captured on a clock edge where `cfg_en` is 1. After reset the captured period is 0x3FFF, so the timer never expires.
- R2: For a period P with 0 < P < 0x3FFF, the elapsed count rises by one on each clock edge where `mtick` is 1. On the edge where the count would reach P, the count returns to zero, and `expired` is 1 for exactly the following clock cycle.
- R3: For a period of 0x0000, `expired` is 1 from the second clock edge after loading and stays 1 until the next load.
- R4: For a period of 0x3FFF, `expired` stays 0.
- R5: A `cyc_start` edge sets the count to zero and produces no expiry, even when `mtick` is 1 on the same edge.
- R6: If `expired` is 1 while `fifo_empty` is 0 and `wm_reached` is 0, `irq_flag` is 1 after the next clock edge.
- R7: An expiry seen while `fifo_empty` or `wm_reached` is 1 does not set `irq_flag`.
- R8: `irq_flag` stays set until an `irq_clr` edge clears it. If a clear arrives on the same edge as a qualifying expiry, the flag stays set.
- R9: Synchronous active-low reset zeroes the count, clears `irq_flag` and drives `expired` to 0.
- R10: Changes on `dur_in` while `cfg_en` is 0 have no effect on the expiry timing.
- R11: While `cfg_en` is 1, the count is held at zero, and `expired` is 0 after each such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Configuration enable; loads `dur_in` and holds the count at zero |
| dur_in | input | 14 | Timer period in macroticks |
| mtick | input | 1 | One-clock macrotick strobe |
| cyc_start | input | 1 | One-clock communication-cycle-start strobe |
| fifo_empty | input | 1 | FIFO holds no entries |
| wm_reached | input | 1 | FIFO fill level has reached the almost-full watermark |
| irq_clr | input | 1 | Software clear pulse for the interrupt flag |
| expired | output | 1 | Timer-expired indication (registered) |
| irq_flag | output | 1 | Sticky almost-full interrupt flag |

## Verification
Each result has a fixed delay after its stimulus:
- `expired` is registered. It reflects the `mtick`/`cyc_start` pair sampled on the previous edge, one clock after that stimulus.
- `irq_flag` follows one edge after `expired` and the FIFO status qualify it, which is two clocks after the macrotick that caused the expiry.
- A newly loaded zero period shows on `expired` one edge after the load edge.

The bench drives every input one time unit after a rising edge. It then advances exactly one edge and compares both outputs with an arithmetic model of count, expiry and flag, so every comparison falls in the cycle where the result is due.

// File: rtl/flush_pkg.sv
// Shared types for the receive FIFO flush timer.
package flush_pkg;
    typedef enum logic [1:0] {
        PMODE_NORMAL = 2'd0,  // count macroticks up to the period
        PMODE_ALWAYS = 2'd1,  // period zero: permanently expired
        PMODE_NEVER  = 2'd2   // period all ones: never expires
    } pmode_t;
endpackage

// File: rtl/flush_cfg.sv
// Holds the programmed period and decodes its reserved values.
// Assumes the period is written only while cfg_en is high.
module flush_cfg #(
    parameter int DUR_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic [DUR_W-1:0]     dur_in,
    output logic [DUR_W-1:0]     dur_q,
    output flush_pkg::pmode_t    mode
);
    import flush_pkg::*;
    localparam logic [DUR_W-1:0] DUR_MAX = {DUR_W{1'b1}};

    // Period register: loads only while configuration is open.
    always_ff @(posedge clk) begin
        if (!rst_n)      dur_q <= DUR_MAX;
        else if (cfg_en) dur_q <= dur_in;
    end

    // Decode of the two reserved values.
    always_comb begin
        if (dur_q == '0)          mode = PMODE_ALWAYS;
        else if (dur_q == DUR_MAX) mode = PMODE_NEVER;
        else                      mode = PMODE_NORMAL;
    end

    // Period may change only on a configuration edge.
    assert_dur_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(dur_q));
endmodule

// File: rtl/flush_count.sv
// Macrotick counter. It restarts on cycle start, on configuration and on
// its own expiry. It flags a hit on the edge where the count reaches the period.
// Assumes mtick and cyc_start are single-clock strobes.
module flush_count #(
    parameter int DUR_W = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hold,
    input  flush_pkg::pmode_t    mode,
    input  logic [DUR_W-1:0]     dur_q,
    input  logic                 mtick,
    input  logic                 cyc_start,
    output logic                 hit
);
    import flush_pkg::*;
    logic [DUR_W-1:0] cnt;
    logic [DUR_W-1:0] cnt_inc;

    // Next count value and the reach-period comparison.
    always_comb begin
        cnt_inc = cnt + 1'b1;
        hit = (mode == PMODE_NORMAL) && !hold && !cyc_start && mtick && (cnt_inc == dur_q);
    end

    // Elapsed-macrotick register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt <= '0;
        else if (hold || cyc_start || mode != PMODE_NORMAL) cnt <= '0;
        else if (mtick)                               cnt <= hit ? '0 : cnt_inc;
    end

    // The count never reaches the period in normal mode.
    assert_cnt_below_dur_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PMODE_NORMAL) |-> (cnt < dur_q));
    // A cycle start wins over a coincident macrotick.
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (cnt == '0));
    // Configuration holds the count at zero.
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (cnt == '0));
endmodule

// File: rtl/flush_irq.sv
// Sticky almost-full interrupt flag. It is set by a qualified expiry and
// cleared by software. On a coincident clear and set, the set wins.
module flush_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic fifo_empty,
    input  logic wm_reached,
    input  logic irq_clr,
    output logic irq_flag
);
    logic qual;

    // An expiry counts only for a non-empty FIFO below the watermark.
    always_comb qual = expired && !fifo_empty && !wm_reached;

    // Flag register: a qualified expiry sets it; it holds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_flag <= 1'b0;
        else        irq_flag <= qual || (irq_flag && !irq_clr);
    end

    assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    assert_irq_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        qual |=> irq_flag);
    assert_irq_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flag && (fifo_empty || wm_reached)) |=> !irq_flag);
endmodule

// File: rtl/fifo_flush_timer.sv
// Top of the receive FIFO periodic flush timer. It drives a registered
// expired indication and a sticky interrupt flag.
// Assumes mtick and cyc_start are synchronous one-clock strobes.
module fifo_flush_timer #(
    parameter int DUR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [DUR_W-1:0] dur_in,
    input  logic             mtick,
    input  logic             cyc_start,
    input  logic             fifo_empty,
    input  logic             wm_reached,
    input  logic             irq_clr,
    output logic             expired,
    output logic             irq_flag
);
    import flush_pkg::*;
    logic [DUR_W-1:0] dur_q;
    pmode_t           mode;
    logic             hit;
    logic             always_on;

    flush_cfg #(.DUR_W(DUR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .dur_in(dur_in),
        .dur_q(dur_q), .mode(mode));

    flush_count #(.DUR_W(DUR_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(cfg_en), .mode(mode), .dur_q(dur_q),
        .mtick(mtick), .cyc_start(cyc_start), .hit(hit));

    // Zero period: expired is held outside configuration.
    always_comb always_on = (mode == PMODE_ALWAYS);

    // Registered expired output.
    always_ff @(posedge clk) begin
        if (!rst_n) expired <= 1'b0;
        else        expired <= !cfg_en && (always_on || hit);
    end

    flush_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expired(expired), .fifo_empty(fifo_empty),
        .wm_reached(wm_reached), .irq_clr(irq_clr), .irq_flag(irq_flag));

    // A normal-period expiry always follows a macrotick.
    assert_pulse_from_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!always_on && !cfg_en && !hit) |=> !expired);
    assert_never_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PMODE_NEVER) |=> !expired);
    assert_always_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (always_on && !cfg_en) |=> expired);
endmodule

// File: tb/tb_fifo_flush_timer.sv
// Self-checking bench: sweeps small periods and macrotick spacings, and
// compares outputs against an arithmetic model every clock.
module tb_fifo_flush_timer;
    localparam int DW = 14;
    localparam logic [DW-1:0] DMAX = {DW{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [DW-1:0] dur_in = '0;
    logic mtick = 1'b0, cyc_start = 1'b0, fifo_empty = 1'b1, wm_reached = 1'b0, irq_clr = 1'b0;
    logic expired, irq_flag;

    int errors = 0, checks = 0;
    int m_dur = int'(DMAX), m_cnt = 0;
    logic m_exp = 1'b0, m_flag = 1'b0;
    string tag_force = "";
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    fifo_flush_timer #(.DUR_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .dur_in(dur_in), .mtick(mtick),
        .cyc_start(cyc_start), .fifo_empty(fifo_empty), .wm_reached(wm_reached),
        .irq_clr(irq_clr), .expired(expired), .irq_flag(irq_flag));

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // One clock with the given strobes; model update; check both outputs.
    task automatic step(input logic mt, input logic cs, input logic clr);
        logic hit, nflag, qual;
        string te, ti;
        mtick = mt; cyc_start = cs; irq_clr = clr;
        @(posedge clk); #1;
        qual  = m_exp && !fifo_empty && !wm_reached;
        nflag = qual || (m_flag && !clr);
        hit = 1'b0;
        if (cfg_en) begin
            m_cnt = 0;
        end else if (m_dur == 0 || m_dur == int'(DMAX)) begin
            m_cnt = 0;
        end else if (cs) begin
            m_cnt = 0;
        end else if (mt) begin
            hit = (m_cnt + 1 == m_dur);
            m_cnt = hit ? 0 : m_cnt + 1;
        end
        m_exp = !cfg_en && (m_dur == 0 || hit);
        if (cfg_en) m_dur = int'(dur_in);
        te = cfg_en ? "R11" : (m_dur == 0) ? "R3" : (m_dur == int'(DMAX)) ? "R4" : cs ? "R5" : "R2";
        ti = (clr && qual) ? "R8" : clr ? "R8" : (m_exp == 1'b0 && (fifo_empty || wm_reached)) ? "R7" : "R6";
        if (tag_force != "") begin te = tag_force; ti = tag_force; end
        m_flag = nflag;
        chk(te, expired, m_exp, "expired");
        chk(ti, irq_flag, m_flag, "irq_flag");
        mtick = 1'b0; cyc_start = 1'b0; irq_clr = 1'b0;
    endtask

    // Load a period (R1): one configuration edge.
    task automatic load(input int d);
        cfg_en = 1'b1; dur_in = DW'(d);
        step(1'b1, 1'b0, 1'b0);
        cfg_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9 reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R9", expired, 1'b0, "expired in reset");
        chk("R9", irq_flag, 1'b0, "irq_flag in reset");
        rst_n = 1'b1;
        // R1: reset period is never-expire
        tag_force = "R1";
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0);
        tag_force = "";
        fifo_empty = 1'b0;
        // R2/R5 sweep over periods and macrotick spacings
        for (int d = 1; d <= 8; d++) begin
            for (int gap = 0; gap < 3; gap++) begin
                load(d);
                for (int t = 0; t < 3 * d + 6; t++) begin
                    step(1'b1, (t == 5 || t == 2 * d + 1), (t % 4) == 3);
                    for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0);
                end
            end
        end
        // R5: cycle starts keep a period of 20 from expiring
        load(20);
        for (int t = 0; t < 60; t++) step(1'b1, (t % 15) == 14, 1'b0);
        // R7: empty FIFO or watermark reached blocks the flag
        step(1'b0, 1'b0, 1'b1);
        load(3);
        fifo_empty = 1'b1;
        for (int t = 0; t < 10; t++) step(1'b1, 1'b0, 1'b0);
        fifo_empty = 1'b0; wm_reached = 1'b1;
        for (int t = 0; t < 10; t++) step(1'b1, 1'b0, 1'b0);
        wm_reached = 1'b0;
        // R3 and R8: zero period, clear coincident with a qualifying expiry
        load(0);
        for (int t = 0; t < 8; t++) step(1'b0, 1'b0, (t % 2) == 1);
        // R4: all-ones period
        load(int'(DMAX));
        step(1'b0, 1'b0, 1'b1);
        for (int t = 0; t < 40; t++) step(1'b1, 1'b0, 1'b0);
        // R10: dur_in changes outside configuration are ignored
        load(4);
        dur_in = DW'(2);
        tag_force = "R10";
        for (int t = 0; t < 16; t++) step(1'b1, 1'b0, 1'b0);
        tag_force = "";
        // R11: configuration edges with macroticks yield no expiry
        for (int t = 0; t < 4; t++) load(1);
        step(1'b1, 1'b0, 1'b0);
        // R9: reset mid-run clears flag and expired
        load(0);
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R9", expired, 1'b0, "expired after reset");
        chk("R9", irq_flag, 1'b0, "irq_flag after reset");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule